// File: doc/BRIEF.md
# Descriptor-Driven Transmit DMA Engine

This block walks a list of transmit descriptors in system memory and streams the frame data they point to into a MAC transmitter. Software builds the descriptors and hands each one to the engine by setting its ownership bit. When the run control is set, the engine loads the list base and fetches descriptors one at a time. For each one it reads the buffer a word at a time and pushes every word onto a valid/ready stream. When a frame ends, the engine waits for the MAC's completion status and writes it back into the descriptor. If the MAC reports a valid timestamp, that is written back as well. The same write returns the descriptor to software.

A frame may span several descriptors. Each descriptor is closed once its buffer has been sent. The engine finds the next descriptor in one of two ways: it steps a fixed stride through a ring that wraps back to the base, or it follows a pointer held in the descriptor. When the engine meets a descriptor that software still owns, it suspends. It resumes on a poll pulse, but only while the underflow flag is clear. Four sticky interrupt flags report frame completion, suspension, underflow and a summary of normal events.

All memory traffic is single words on a request/acknowledge port, using word addresses. `mem_req` is held, with its address, direction and write data stable, until `mem_ack` pulses for one cycle. Read data is valid during that cycle. A request seen in the same cycle as its acknowledge belongs to the finished transfer. On the output stream, once `tx_valid` is high, it stays high with `tx_data` and `tx_last` unchanged until the cycle in which `tx_ready` is high. A beat transfers at each clock edge where both are high. A last-segment buffer must hold at least one word.

Top module: `txd_dma`

## Requirements
- R1: After reset all four flags are 0, `mem_req` is low, `tx_valid` is low, and the engine is stopped.
- R2: When `cfg_run` is seen high while the engine is stopped, the descriptor pointer is loaded from `cfg_base` and the first memory read is word 0 at that address. Descriptor word 0 bit 31 set means the engine owns the descriptor.
- R3: If a fetched word 0 has bit 31 clear, the engine suspends. It makes no further memory access and sets the suspend flag (bit 1) and the summary flag (bit 3).
- R4: A suspended engine re-reads the same word 0 on a `cfg_poll` pulse only while the underflow flag (bit 2) is clear. A poll seen while that flag is set is dropped.
- R5: Word 1 holds the buffer length in words and word 2 holds the buffer address. The buffer words are sent in address order, and each beat is held stable until it is accepted.
- R6: `tx_last` is high only on the final beat of a buffer whose descriptor has the last-segment bit (word 0 bit 29) set.
- R7: A descriptor without bit 29 is closed right after its buffer is sent. Word 0 is rewritten with bit 31 cleared, bits 30:16 kept, and bits 15:0 zero.
- R8: After the last beat of a last-segment buffer, the engine waits for `mac_done`. If `mac_ts_ok` is set, it writes `mac_ts[31:0]` to word 6 and `mac_ts[63:32]` to word 7. It then writes word 0 as {0, word 0 bits 30:16, `mac_status`}. Without `mac_ts_ok`, words 6 and 7 are left unchanged.
- R9: Without the chained bit, the next descriptor is 8 words on. If the ring-end bit (word 0 bit 21) is set, the next descriptor is `cfg_base` instead.
- R10: With the chained bit (word 0 bit 20) set, word 3 is read and used as the next descriptor address.
- R11: When a last-segment descriptor with bit 30 set is closed, the completion flag (bit 0) and the summary flag (bit 3) are set. Without bit 30, no completion flag is set.
- R12: The flags are sticky. Bit 2 is set by `mac_underflow`. A 1 in `irq_clr` clears the matching flag, and a set in the same cycle wins over the clear.
- R13: Once `cfg_run` is low, the engine finishes the descriptor in hand through its word 0 writeback and then stops. A suspended engine stops at once. While stopped, polls are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Run enable level |
| cfg_poll | input | 1 | Poll-demand pulse |
| cfg_base | input | AW | Descriptor list base (word address) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | One-cycle acknowledge |
| tx_data | output | 32 | Stream data word |
| tx_valid | output | 1 | Stream valid |
| tx_ready | input | 1 | Stream ready |
| tx_last | output | 1 | Final beat of frame |
| mac_done | input | 1 | Frame completion pulse |
| mac_status | input | 16 | Completion status code |
| mac_ts_ok | input | 1 | Timestamp valid with `mac_done` |
| mac_ts | input | 64 | Frame timestamp |
| mac_underflow | input | 1 | Underflow event pulse |
| irq_clr | input | 4 | Write-one-to-clear flag pulses |
| irq_flags | output | 4 | Flags: 0 completion, 1 suspend, 2 underflow, 3 summary |

## Verification
The bench drives the engine through four list shapes, each of which separates a different fault:
- A three-entry ring holds a single-buffer frame with timestamp, a two-buffer frame without timestamp, and a wrap back to a descriptor already returned to software. This separates the stride step from the ring-end wrap, and intermediate closes from final status writes.
- A chained single-buffer frame whose pointer leads to a host-owned entry shows whether word 3 is really followed and whether the completion flag stays quiet without bit 30.
- A poll while the underflow flag is set, and another while stopped, must cause no memory reads.
- Dropping the run level in the middle of a buffer must still yield the complete buffer and its close, and no fetch beyond it.

Throughout, `tx_ready` is toggled in a pseudo-random pattern, which catches beats that are lost or duplicated under back-pressure.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // descriptor word 0 bit positions
  localparam int OWN_B = 31;
  localparam int IOC_B = 30;
  localparam int LS_B  = 29;
  localparam int RER_B = 21;
  localparam int CHN_B = 20;
  localparam int CTRL_LO = 16;   // bits 30:16 are kept across writeback
  localparam int CTRL_W  = 15;

  // word offsets inside a descriptor
  localparam int OFF_LEN = 1;
  localparam int OFF_BUF = 2;
  localparam int OFF_NXT = 3;
  localparam int OFF_TSL = 6;
  localparam int OFF_TSH = 7;
  localparam int DESC_WORDS = 8;

  // flag indices
  localparam int FL_TI  = 0;
  localparam int FL_TU  = 1;
  localparam int FL_UNF = 2;
  localparam int FL_NIS = 3;
  localparam int FL_N   = 4;

  typedef enum logic [3:0] {
    S_STOP, S_RD0, S_RD1, S_RD2, S_RD3, S_RDBUF, S_PUSH,
    S_WSTS, S_WTS6, S_WTS7, S_WR0, S_SUSP
  } txd_state_e;
endpackage

// File: rtl/txd_next.sv
module txd_next
  import txd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] chain_ptr,
  input  logic          chain_en,
  input  logic          ring_end,
  output logic [AW-1:0] next_addr
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_WORDS);

  always_comb begin
    if (chain_en)      next_addr = chain_ptr;
    else if (ring_end) next_addr = base;
    else               next_addr = ptr + STRIDE;
  end
endmodule

// File: rtl/txd_flags.sv
module txd_flags
  import txd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_ti,
  input  logic            set_tu,
  input  logic            set_unf,
  input  logic [FL_N-1:0] clr,
  output logic [FL_N-1:0] flags
);
  logic [FL_N-1:0] set_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[FL_TI]  = set_ti;
    set_vec[FL_TU]  = set_tu;
    set_vec[FL_UNF] = set_unf;
    set_vec[FL_NIS] = set_ti | set_tu;
  end

  for (genvar i = 0; i < FL_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_vec[i] | (flags[i] & ~clr[i]);
    end
  end

  // R3: suspension raises its flag and the summary together
  p_tu_sets_nis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_tu |=> (flags[FL_TU] && flags[FL_NIS]));

  // R12: a flag not set and not cleared keeps its value
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_UNF] && !clr[FL_UNF]) |=> flags[FL_UNF]);
endmodule

// File: rtl/txd_core.sv
module txd_core
  import txd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          poll,
  input  logic [AW-1:0] list_base,
  input  logic          unf_flag,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic [31:0]   tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  input  logic          sts_valid,
  input  logic [15:0]   sts_code,
  input  logic          sts_ts_ok,
  input  logic [63:0]   sts_ts,
  input  logic [AW-1:0] next_addr,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] chain_ptr,
  output logic          chain_en,
  output logic          ring_end,
  output logic          set_ti,
  output logic          set_tu
);
  localparam int I_IOC = IOC_B - CTRL_LO;
  localparam int I_LS  = LS_B  - CTRL_LO;
  localparam int I_RER = RER_B - CTRL_LO;
  localparam int I_CHN = CHN_B - CTRL_LO;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  txd_state_e        state;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  beats;
  logic [LEN_W-1:0]  idx;
  logic [AW-1:0]     buf_q;
  logic [31:0]       data_q;
  logic [15:0]       sts_q;
  logic [63:0]       ts_q;
  logic              is_last;

  assign is_last  = ctrl_q[I_LS];
  assign chain_en = ctrl_q[I_CHN];
  assign ring_end = ctrl_q[I_RER];

  // where to go once the descriptor words are in
  function automatic txd_state_e after_fetch(input logic [LEN_W-1:0] n, input logic ls);
    if (n != '0) return S_RDBUF;
    else if (ls) return S_WSTS;
    else         return S_WR0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_STOP;
      ptr       <= '0;
      chain_ptr <= '0;
      ctrl_q    <= '0;
      beats     <= '0;
      idx       <= '0;
      buf_q     <= '0;
      data_q    <= '0;
      sts_q     <= '0;
      ts_q      <= '0;
    end else begin
      unique case (state)
        S_STOP: if (run) begin
          ptr   <= list_base;
          state <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (!run)                    state <= S_STOP;
          else if (!mem_rdata[OWN_B])  state <= S_SUSP;
          else begin
            ctrl_q <= mem_rdata[CTRL_LO+CTRL_W-1:CTRL_LO];
            state  <= S_RD1;
          end
        end
        S_RD1: if (mem_ack) begin
          beats <= mem_rdata[LEN_W-1:0];
          state <= S_RD2;
        end
        S_RD2: if (mem_ack) begin
          buf_q <= mem_rdata[AW-1:0];
          idx   <= '0;
          state <= chain_en ? S_RD3 : after_fetch(beats, is_last);
        end
        S_RD3: if (mem_ack) begin
          chain_ptr <= mem_rdata[AW-1:0];
          state     <= after_fetch(beats, is_last);
        end
        S_RDBUF: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_PUSH;
        end
        S_PUSH: if (tx_ready) begin
          beats <= beats - ONE;
          idx   <= idx + ONE;
          if (beats == ONE) state <= is_last ? S_WSTS : S_WR0;
          else              state <= S_RDBUF;
        end
        S_WSTS: if (sts_valid) begin
          sts_q <= sts_code;
          ts_q  <= sts_ts;
          state <= sts_ts_ok ? S_WTS6 : S_WR0;
        end
        S_WTS6: if (mem_ack) state <= S_WTS7;
        S_WTS7: if (mem_ack) state <= S_WR0;
        S_WR0: if (mem_ack) begin
          ptr   <= next_addr;
          state <= run ? S_RD0 : S_STOP;
        end
        S_SUSP: begin
          if (!run)                   state <= S_STOP;
          else if (poll && !unf_flag) state <= S_RD0;
        end
        default: state <= S_STOP;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_RD0:   mem_addr = ptr;
      S_RD1:   mem_addr = ptr + AW'(OFF_LEN);
      S_RD2:   mem_addr = ptr + AW'(OFF_BUF);
      S_RD3:   mem_addr = ptr + AW'(OFF_NXT);
      S_RDBUF: mem_addr = buf_q + AW'(idx);
      S_WTS6: begin
        mem_we = 1'b1; mem_addr = ptr + AW'(OFF_TSL); mem_wdata = ts_q[31:0];
      end
      S_WTS7: begin
        mem_we = 1'b1; mem_addr = ptr + AW'(OFF_TSH); mem_wdata = ts_q[63:32];
      end
      S_WR0: begin
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = {1'b0, ctrl_q, (is_last ? sts_q : 16'h0000)};
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign tx_valid = (state == S_PUSH);
  assign tx_data  = data_q;
  assign tx_last  = (state == S_PUSH) && is_last && (beats == ONE);

  assign set_tu = (state == S_RD0) && mem_ack && run && !mem_rdata[OWN_B];
  assign set_ti = (state == S_WR0) && mem_ack && is_last && ctrl_q[I_IOC];

  // R2: a memory request and its address hold until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5: a stalled beat keeps its data
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R6: last only marks a real beat
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R13: suspended with run low goes straight to stopped
  p_susp_stop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP && !run) |=> (state == S_STOP));

  // R3: suspension issues no memory traffic
  p_susp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SUSP) |-> !mem_req);
endmodule

// File: rtl/txd_dma.sv
module txd_dma
  import txd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_poll,
  input  logic [AW-1:0] cfg_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic [31:0]   tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  input  logic          mac_done,
  input  logic [15:0]   mac_status,
  input  logic          mac_ts_ok,
  input  logic [63:0]   mac_ts,
  input  logic          mac_underflow,
  input  logic [3:0]    irq_clr,
  output logic [3:0]    irq_flags
);
  logic [AW-1:0] ptr, chain_ptr, next_addr;
  logic          chain_en, ring_end, set_ti, set_tu;

  txd_core #(.AW(AW), .LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(cfg_run), .poll(cfg_poll),
    .list_base(cfg_base), .unf_flag(irq_flags[FL_UNF]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .sts_valid(mac_done), .sts_code(mac_status),
    .sts_ts_ok(mac_ts_ok), .sts_ts(mac_ts), .next_addr(next_addr),
    .ptr(ptr), .chain_ptr(chain_ptr), .chain_en(chain_en),
    .ring_end(ring_end), .set_ti(set_ti), .set_tu(set_tu)
  );

  txd_next #(.AW(AW)) u_next (
    .ptr(ptr), .base(cfg_base), .chain_ptr(chain_ptr),
    .chain_en(chain_en), .ring_end(ring_end), .next_addr(next_addr)
  );

  txd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ti(set_ti), .set_tu(set_tu),
    .set_unf(mac_underflow), .clr(irq_clr), .flags(irq_flags)
  );
endmodule

// File: tb/txd_dma_test.sv
module txd_dma_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_run = 1'b0, cfg_poll = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata, tx_data;
  logic          tx_valid, tx_ready, tx_last;
  logic          mac_done, mac_ts_ok, mac_underflow = 1'b0;
  logic [15:0]   mac_status, fnum;
  logic [63:0]   mac_ts;
  logic [3:0]    irq_clr = '0, irq_flags;
  logic [1:0]    dcnt;
  logic [7:0]    lfsr;
  logic          stall_on = 1'b1;

  logic [31:0] mem [0:255];
  logic [7:0]  last_desc_rd, first_rd;
  int          rd_count, beats;
  int          checks = 0, errors = 0;
  logic [32:0] expq[$];

  always #10 clk = ~clk;

  txd_dma #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_poll(cfg_poll),
    .cfg_base(cfg_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .mac_done(mac_done),
    .mac_status(mac_status), .mac_ts_ok(mac_ts_ok), .mac_ts(mac_ts),
    .mac_underflow(mac_underflow), .irq_clr(irq_clr), .irq_flags(irq_flags)
  );

  function automatic logic [31:0] fill(input int a);
    return 32'hDEAD_0000 | 32'(a);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one acknowledge per request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; rd_count <= 0;
      last_desc_rd <= '0; first_rd <= 8'hFF;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else begin
          mem_rdata <= mem[mem_addr[7:0]];
          rd_count  <= rd_count + 1;
          if (rd_count == 0) first_rd <= mem_addr[7:0];
          if (mem_addr[7:0] < 8'h80 && mem_addr[2:0] == 3'd0) last_desc_rd <= mem_addr[7:0];
        end
      end
    end
  end

  // MAC model: completion pulse three cycles after the last beat
  always @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0; mac_done <= 1'b0; fnum <= '0; lfsr <= 8'h5A; tx_ready <= 1'b0;
    end else begin
      mac_done <= 1'b0;
      if (tx_valid && tx_ready && tx_last) dcnt <= 2'd3;
      else if (dcnt != 0) begin
        dcnt <= dcnt - 2'd1;
        if (dcnt == 2'd1) mac_done <= 1'b1;
      end
      if (mac_done) fnum <= fnum + 16'd1;
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= stall_on ? lfsr[0] : 1'b1;
    end
  end
  assign mac_status = 16'hA000 + fnum;
  assign mac_ts_ok  = !fnum[0];
  assign mac_ts     = {32'h5151_0000 + 32'(fnum), 32'hC0C0_0000 + 32'(fnum)};

  // scoreboard monitor (R5, R6)
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      beats++;
      if (expq.size() == 0) chk("R5 unexpected beat", {31'd0, tx_last, tx_data}, 64'd0);
      else begin
        logic [32:0] e;
        e = expq.pop_front();
        chk("R5/R6 beat", {31'd0, tx_last, tx_data}, {31'd0, e});
      end
    end
  end

  task automatic push_buf(input int a, input int n, input logic ls);
    for (int i = 0; i < n; i++) expq.push_back({(ls && i == n-1), fill(a+i)});
  endtask

  task automatic put(input int a, input logic [31:0] v);
    mem[a] <= v;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    @(negedge clk) irq_clr = m;
    @(negedge clk) irq_clr = '0;
  endtask

  task automatic pulse_poll();
    @(negedge clk) cfg_poll = 1'b1;
    @(negedge clk) cfg_poll = 1'b0;
  endtask

  task automatic wait_tu(input string tag);
    int n = 0;
    while (!irq_flags[1] && n < 5000) begin @(negedge clk); n++; end
    chk(tag, {63'd0, irq_flags[1]}, 64'd1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int rc, bc;
    beats = 0;
    for (int i = 0; i < 256; i++) mem[i] = fill(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", {60'd0, irq_flags}, 64'd0);
    chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 tx_valid", {63'd0, tx_valid}, 64'd0);

    // ring: A (single, IOC), B (first of two), C (last, ring end)
    put(8'h10, 32'hF000_0000); put(8'h11, 3); put(8'h12, 32'h80);
    put(8'h18, 32'h9000_0000); put(8'h19, 2); put(8'h1A, 32'h90);
    put(8'h20, 32'hA020_0000); put(8'h21, 1); put(8'h22, 32'hA0);
    push_buf(8'h80, 3, 1'b1); push_buf(8'h90, 2, 1'b0); push_buf(8'hA0, 1, 1'b1);
    @(negedge clk);
    cfg_base = 16'h0010; cfg_run = 1'b1;
    wait_tu("R3 suspend on host-owned");
    chk("R2 first read at base", {56'd0, first_rd}, 64'h10);
    chk("R9 ring wrap to base", {56'd0, last_desc_rd}, 64'h10);
    chk("R11 flags TI+TU+NIS", {60'd0, irq_flags}, 64'hB);
    chk("R8 A status", {32'd0, mem[8'h10]}, 64'h7000_A000);
    chk("R8 A ts low", {32'd0, mem[8'h16]}, 64'hC0C0_0000);
    chk("R8 A ts high", {32'd0, mem[8'h17]}, 64'h5151_0000);
    chk("R7 B close", {32'd0, mem[8'h18]}, 64'h1000_0000);
    chk("R9 C status", {32'd0, mem[8'h20]}, 64'h2020_A001);
    chk("R8 C word6 untouched", {32'd0, mem[8'h26]}, {32'd0, fill(8'h26)});
    chk("R8 C word7 untouched", {32'd0, mem[8'h27]}, {32'd0, fill(8'h27)});
    chk("R6 beats ring", beats, 6);
    rc = rd_count;
    repeat (20) @(negedge clk);
    chk("R3 no access while suspended", rd_count, rc);

    pulse_clr(4'b0001);
    chk("R12 clear TI only", {60'd0, irq_flags}, 64'hA);
    pulse_clr(4'b1111);
    chk("R12 clear all", {60'd0, irq_flags}, 64'h0);
    @(negedge clk) mac_underflow = 1'b1;
    @(negedge clk) mac_underflow = 1'b0;
    chk("R12 underflow flag", {60'd0, irq_flags}, 64'h4);

    // chained A pointing at host-owned D
    put(8'h10, 32'hB010_0000); put(8'h11, 2); put(8'h12, 32'hB0); put(8'h13, 32'h40);
    put(8'h40, 32'h1000_0000);
    push_buf(8'hB0, 2, 1'b1);
    rc = rd_count;
    pulse_poll();
    repeat (20) @(negedge clk);
    chk("R4 poll blocked by underflow", rd_count, rc);
    pulse_clr(4'b0100);
    pulse_poll();
    wait_tu("R4 resume after poll");
    chk("R10 chain followed", {56'd0, last_desc_rd}, 64'h40);
    chk("R11 no TI without IOC", {60'd0, irq_flags}, 64'hA);
    chk("R8 chained status", {32'd0, mem[8'h10]}, 64'h3010_A002);
    chk("R8 chained ts low", {32'd0, mem[8'h16]}, 64'hC0C0_0002);
    chk("R8 chained ts high", {32'd0, mem[8'h17]}, 64'h5151_0002);

    // stop mid-buffer
    stall_on = 1'b0;
    put(8'h40, 32'h9000_0000); put(8'h41, 4); put(8'h42, 32'hC0);
    push_buf(8'hC0, 4, 1'b0);
    pulse_clr(4'b1111);
    bc = beats;
    pulse_poll();
    while (beats < bc + 2) @(negedge clk);
    cfg_run = 1'b0;
    repeat (40) @(negedge clk);
    chk("R13 buffer finished", beats, bc + 4);
    chk("R13 descriptor closed", {32'd0, mem[8'h40]}, 64'h1000_0000);
    chk("R13 no further fetch", {56'd0, last_desc_rd}, 64'h40);
    chk("R13 idle after stop", {63'd0, mem_req}, 64'd0);
    rc = rd_count;
    pulse_poll();
    repeat (10) @(negedge clk);
    chk("R13 poll ignored when stopped", rd_count, rc);

    cfg_run = 1'b1;
    wait_tu("R2 restart");
    chk("R2 restart at base", {56'd0, last_desc_rd}, 64'h10);
    chk("R3 flags after restart", {60'd0, irq_flags}, 64'hA);
    chk("R5 scoreboard drained", expq.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule